// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives two audio clocks from one module clock: a master clock for an external converter and a serial bit clock for the sample stream. Each clock has its own 4-bit divide code in a 10-bit control word. The code selects a ratio from a fixed set that is not a series of powers of two, for example 6, 12, 24, 48, 96, 176 and 192. Every ratio except 1 is even, so each divided clock is a square wave with 50% duty cycle. Ratio 1 passes the module clock straight through.

Software writes the control word through a plain write port. A code written while a clock is running is held as pending. It becomes active only when the current period ends, at the close of its high half, so no shortened pulse is produced. Code 0 has no ratio. It raises a per-channel error bit, and the affected output stays low. Each output has its own enable. While an enable is low the output is held low, but the divider keeps counting so the clock's phase is preserved. A synchronous reset clears both dividers and forces both outputs low.

With a 24.576 MHz module clock and 48 kHz stereo frames of 32-bit slots, code 5 (ratio 8) on the bit clock and code 1 (ratio 1) on the master clock give the required rates.

Top module: `aud_clkgen`

## Requirements
- R1: A divide code maps to a ratio as follows: 1→1, 2→2, 3→4, 4→6, 5→8, 6→12, 7→16, 8→24, 9→32, 10→48, 11→64, 12→96, 13→128, 14→176, 15→192.
- R2: Code 0 is invalid. `code_err_o[0]` is set while the master code is 0 and `code_err_o[1]` while the bit code is 0, and an output whose active code is 0 stays low.
- R3: Control word layout: bits [3:0] are the master clock code, bits [7:4] the bit clock code, bit 8 the master clock enable and bit 9 the bit clock enable. A write on `wr_en` replaces the whole word.
- R4: For every even ratio N, the output is high for exactly N/2 module clocks and low for exactly N/2 module clocks.
- R5: For ratio 1 an enabled output follows the module clock: high while the clock is high and low while it is low.
- R6: A new code takes effect only at the end of a high half of the current period. Every complete high or low interval therefore has the half length of either the old ratio or the new one.
- R7: While an output's enable is 0, that output is low and its divider keeps counting. After the enable returns, rising edges stay spaced by whole periods from the rising edges seen before it was cleared.
- R8: While `srst` is high both outputs are low and both dividers are cleared. After `srst` falls, the dividers restart with the stored codes.
- R9: After asynchronous reset the control word is zero: `code_err_o` = 2'b11 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous divider clear |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 10 | Control word to write |
| mclk_o | output | 1 | Divided master clock |
| bclk_o | output | 1 | Divided bit clock |
| code_err_o | output | 2 | Invalid code flags, bit 0 master, bit 1 bit clock |

## Verification
The assertions check on every cycle that an active code changes only after a high half, after an invalid or unit ratio, or under synchronous reset. They also check that synchronous reset clears the divider state, that writing code 0 raises the error bit, and that clearing the bit clock enable forces the output low on the next cycle. Only the bench's scenarios can show the decode table, the exact high and low interval lengths, and that phase is kept across an enable gap. The same holds for the pass-through at ratio 1 and for interval lengths across a code change in either direction. The bench measures these as interval lengths and edge spacing at the outputs.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;
  localparam int CODE_W  = 4;
  localparam int N_CLK   = 2;
  localparam int WORD_W  = N_CLK * CODE_W + N_CLK;
  localparam int EN_LSB  = N_CLK * CODE_W;
  localparam int HALF_W  = 7;

  typedef logic [CODE_W-1:0] div_code_t;
  typedef logic [HALF_W-1:0] half_t;

  // Half-period length in module clocks; 0 marks codes 0 and 1.
  function automatic half_t code_to_half(input div_code_t code);
    case (code)
      4'd2:    code_to_half = half_t'(1);
      4'd3:    code_to_half = half_t'(2);
      4'd4:    code_to_half = half_t'(3);
      4'd5:    code_to_half = half_t'(4);
      4'd6:    code_to_half = half_t'(6);
      4'd7:    code_to_half = half_t'(8);
      4'd8:    code_to_half = half_t'(12);
      4'd9:    code_to_half = half_t'(16);
      4'd10:   code_to_half = half_t'(24);
      4'd11:   code_to_half = half_t'(32);
      4'd12:   code_to_half = half_t'(48);
      4'd13:   code_to_half = half_t'(64);
      4'd14:   code_to_half = half_t'(88);
      4'd15:   code_to_half = half_t'(96);
      default: code_to_half = half_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/aud_clkgen_decode.sv
module aud_clkgen_decode
  import aud_clkgen_pkg::*;
(
  input  div_code_t code_i,
  output half_t     half_o,
  output logic      unit_o,
  output logic      bad_o
);
  always_comb begin
    half_o = code_to_half(code_i);
    unit_o = (code_i == div_code_t'(1));
    bad_o  = (code_i == div_code_t'(0));
  end
endmodule

// File: rtl/aud_clkgen_div.sv
module aud_clkgen_div
  import aud_clkgen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      srst,
  input  div_code_t code_i,
  input  logic      en_i,
  output logic      div_o,
  output div_code_t act_code_o,
  output logic      phase_o
);
  div_code_t act_q, act_d;
  half_t     cnt_q, cnt_d;
  logic      ph_q, ph_d;
  half_t     half;
  logic      unit, bad, at_half, tc;

  aud_clkgen_decode u_dec (
    .code_i (act_q),
    .half_o (half),
    .unit_o (unit),
    .bad_o  (bad)
  );

  // next-state
  always_comb begin
    at_half = (cnt_q == half - half_t'(1));
    tc      = bad | unit | (ph_q & at_half);
    act_d   = act_q;
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    if (srst) begin
      act_d = '0;
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tc) begin
      act_d = code_i;
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (at_half) begin
      cnt_d = '0;
      ph_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + half_t'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign div_o      = en_i & ~srst & (unit ? clk : ph_q);
  assign act_code_o = act_q;
  assign phase_o    = ph_q;
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic [N_CLK-1:0]  code_err_o
);
  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic [N_CLK-1:0]  div_out;
  logic [N_CLK-1:0]  ph;
  div_code_t         act_code [N_CLK];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // channel 0 = master clock, channel 1 = bit clock
  for (genvar g = 0; g < N_CLK; g++) begin : gen_ch
    assign code_err_o[g] = (cfg_q[g*CODE_W +: CODE_W] == div_code_t'(0));
    aud_clkgen_div u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst),
      .code_i     (cfg_q[g*CODE_W +: CODE_W]),
      .en_i       (cfg_q[EN_LSB + g]),
      .div_o      (div_out[g]),
      .act_code_o (act_code[g]),
      .phase_o    (ph[g])
    );
  end

  assign mclk_o = div_out[0];
  assign bclk_o = div_out[1];
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk
  import aud_clkgen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              srst,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              bclk_o,
  input logic [N_CLK-1:0]  code_err_o,
  input div_code_t         act_m,
  input div_code_t         act_b,
  input logic              ph_m,
  input logic              ph_b
);
  a_r2_err_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3:0] == 4'd0) |=> code_err_o[0]);

  a_r6_reload_master: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m != $past(act_m)) |->
      ($past(ph_m) || $past(srst) || $past(act_m) == 4'd0 || $past(act_m) == 4'd1));

  a_r6_reload_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b != $past(act_b)) |->
      ($past(ph_b) || $past(srst) || $past(act_b) == 4'd0 || $past(act_b) == 4'd1));

  a_r8_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (act_m == 4'd0 && act_b == 4'd0 && !ph_m && !ph_b));

  a_r7_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[9]) |=> !bclk_o);
endmodule

bind aud_clkgen aud_clkgen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srst       (srst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .bclk_o     (bclk_o),
  .code_err_o (code_err_o),
  .act_m      (act_code[0]),
  .act_b      (act_code[1]),
  .ph_m       (ph[0]),
  .ph_b       (ph[1])
);

// File: tb/aud_clkgen_tb.sv
`timescale 1ns/1ps
module aud_clkgen_tb;
  logic       clk, rst_n, srst, wr_en;
  logic [9:0] wr_data;
  logic       mclk_o, bclk_o;
  logic [1:0] code_err_o;
  int n_chk, n_bad, cyc;

  aud_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .wr_data(wr_data),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .code_err_o(code_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ratio_of(input int code);
    case (code)
      1: return 1;   2: return 2;   3: return 4;    4: return 6;
      5: return 8;   6: return 12;  7: return 16;   8: return 24;
      9: return 32;  10: return 48; 11: return 64;  12: return 96;
      13: return 128; 14: return 176; 15: return 192;
      default: return 0;
    endcase
  endfunction

  function automatic logic sig(input int w);
    return (w == 0) ? mclk_o : bclk_o;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input int mc, input int bc, input bit me, input bit be);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {be, me, 4'(bc), 4'(mc)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // measure complete high/low intervals at negedge samples
  task automatic runs(input int w, input int ha, input int hb, input int n, input string rq);
    logic prev, cur;
    int len, tmo;
    @(negedge clk); prev = sig(w);
    tmo = 0;
    do begin @(negedge clk); cur = sig(w); tmo++; end while (cur == prev && tmo < 1000);
    prev = cur;
    for (int r = 0; r < n; r++) begin
      len = 0;
      do begin @(negedge clk); cur = sig(w); len++; end while (cur == prev && len < 1000);
      prev = cur;
      check(len == ha || len == hb, rq, len, ha);
    end
  endtask

  task automatic wait_rise(input int w, output int t);
    logic prev;
    int tmo;
    @(negedge clk); prev = sig(w); tmo = 0;
    while (!(sig(w) && !prev) && tmo < 1000) begin
      prev = sig(w); @(negedge clk); tmo++;
    end
    t = cyc;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, t1, mc, bc, stuck;
    void'($urandom(32'h5eed_1234));
    cyc = 0; n_chk = 0; n_bad = 0;
    rst_n = 1'b0; srst = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(code_err_o == 2'b11, "R9", code_err_o, 3);
    check(mclk_o == 1'b0 && bclk_o == 1'b0, "R9", {mclk_o, bclk_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(code_err_o == 2'b11, "R9", code_err_o, 3);

    // R3/R5: master code 1 passthrough, bit code 5 -> ratio 8
    wr(1, 5, 1'b1, 1'b1);
    check(code_err_o == 2'b00, "R3", code_err_o, 0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(mclk_o == 1'b1, "R5", mclk_o, 1);
      @(negedge clk); #2;
      check(mclk_o == 1'b0, "R5", mclk_o, 0);
    end
    runs(1, 4, 4, 4, "R4");

    // R1/R4: random codes 2..15 on both clocks
    for (int it = 0; it < 12; it++) begin
      mc = 2 + ($urandom % 14);
      bc = 2 + ($urandom % 14);
      wr(mc, bc, 1'b1, 1'b1);
      repeat (400) @(negedge clk);
      runs(0, ratio_of(mc) / 2, ratio_of(mc) / 2, 3, "R1");
      runs(1, ratio_of(bc) / 2, ratio_of(bc) / 2, 3, "R1");
    end
    // directed extremes
    wr(15, 2, 1'b1, 1'b1);
    repeat (400) @(negedge clk);
    runs(0, 96, 96, 2, "R1");
    runs(1, 1, 1, 4, "R4");
    wr(14, 4, 1'b1, 1'b1);
    repeat (400) @(negedge clk);
    runs(0, 88, 88, 2, "R1");
    runs(1, 3, 3, 4, "R4");

    // R6: code change mid-period in both directions
    wr(2, 5, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    repeat ($urandom % 8) @(negedge clk);
    wr(2, 15, 1'b1, 1'b1);
    runs(1, 4, 96, 4, "R6");
    repeat ($urandom % 90) @(negedge clk);
    wr(2, 3, 1'b1, 1'b1);
    runs(1, 96, 2, 6, "R6");

    // R2: invalid code 0 on the bit clock
    wr(2, 0, 1'b1, 1'b1);
    check(code_err_o == 2'b10, "R2", code_err_o, 2);
    stuck = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (bclk_o) stuck++; end
    check(stuck == 0, "R2", stuck, 0);
    wr(0, 5, 1'b1, 1'b1);
    check(code_err_o == 2'b01, "R2", code_err_o, 1);
    stuck = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); #1; if (mclk_o) stuck++; end
    check(stuck == 0, "R2", stuck, 0);

    // R7: enable gating keeps phase
    wr(1, 5, 1'b0, 1'b1);
    stuck = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #2; if (mclk_o) stuck++;
    end
    check(stuck == 0, "R7", stuck, 0);
    repeat (20) @(negedge clk);
    wait_rise(1, t0);
    wr(1, 5, 1'b0, 1'b0);
    stuck = 0;
    for (int i = 0; i < 13; i++) begin @(negedge clk); if (bclk_o) stuck++; end
    check(stuck == 0, "R7", stuck, 0);
    wr(1, 5, 1'b0, 1'b1);
    wait_rise(1, t1);
    check(((t1 - t0) % 8) == 0, "R7", (t1 - t0) % 8, 0);

    // R8: synchronous clear
    wr(1, 6, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    srst = 1'b1;
    stuck = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2; if (mclk_o || bclk_o) stuck++;
      @(negedge clk); #1; if (mclk_o || bclk_o) stuck++;
    end
    check(stuck == 0, "R8", stuck, 0);
    srst = 1'b0;
    runs(1, 6, 6, 4, "R8");
    @(posedge clk); #2;
    check(mclk_o == 1'b1, "R8", mclk_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule